// File: doc/BRIEF.md
# Timed Dodge Button Controller

This block turns a raw push-button into a dodge flag of limited length. When the button is pressed, the flag rises and stays high for a programmed number of tick-enable cycles. It then drops on its own, even if the button is still held. After that the controller waits for the button to be released before it will accept another press. Holding the button down therefore gives one window of protection, not a permanent one, and it cannot chain windows back to back.

The button passes through a two-flop synchronizer before the state machine sees it. The window length is a live input. It is captured at the moment a dodge begins, so the surrounding logic can shorten it as play gets harder without disturbing a window that is already running. The tick enable lets a slow game rate drive the timer while the block runs on the fast system clock. A visible state code is provided alongside the flag.

Top module: `dodge_ctrl`

## Requirements
- R1: `state_o` reports the controller phase with the codes 0 = ready, 1 = dodging, 2 = release-wait; code 3 never appears.
- R2: A synchronous active-high reset puts the controller in ready (`state_o` = 0) with `dodge_o` low. The reset can arrive in any phase.
- R3: While in ready and the synchronized button reads low, the controller remains in ready and `dodge_o` stays low.
- R4: `btn_i` reaches the state machine through two flip-flops. A press seen in ready enters dodging on the third rising clock edge after `btn_i` goes high. `dodge_o` is high exactly when `state_o` = 1.
- R5: The window counter clears on entry to dodging and advances only on cycles with `tick_i` high. Dodging ends on the edge that carries the N-th tick, where N is the captured duration. Cycles without a tick never shorten the window.
- R6: Dodging always ends after its ticks, even with the button held. The controller then enters release-wait and stays there as long as the synchronized button reads high.
- R7: From release-wait, the controller returns to ready on the edge after the synchronized button reads low. That is the third rising edge after `btn_i` falls.
- R8: A captured duration of zero behaves as one tick.
- R9: `dur_i` is sampled on the edge that enters dodging. Later changes to `dur_i` do not alter the running window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Game-rate tick enable for the window counter |
| btn_i | input | 1 | Raw, asynchronous dodge button |
| dur_i | input | DUR_W | Window length in ticks, captured when a dodge starts |
| dodge_o | output | 1 | High while the dodge window is open |
| state_o | output | 2 | Phase code: 0 ready, 1 dodging, 2 release-wait |

## Verification
The embedded assertions check the following on every cycle:
- the legal state transitions out of each phase;
- that the counter clears on entry, holds on tickless cycles and stays below the captured duration;
- that the captured duration is nonzero and frozen while dodging;
- the two-cycle synchronizer delay.

The absolute length of a window can only be shown by the bench's scenarios. The same holds for the behaviour of zero and changing durations, sparse ticks, a button held long past the window, and a reset mid-dodge. The bench's cycle model is compared against both outputs on every clock to cover these cases.

// File: rtl/dodge_pkg.sv
package dodge_pkg;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RELEASE = 2'd2
    } dodge_state_e;

    localparam int SYNC_STAGES = 2;

    function automatic logic is_dodging(input dodge_state_e s);
        return s == ST_ACTIVE;
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[LAST-1:0], async_i};
    end

    assign sync_o = chain_q[LAST];

    // Synchronizer latency: output follows the raw input two edges later (R4)
    p_sync_delay_r4: assert property (@(posedge clk_i)
        (!rst_i && $past(!rst_i) && $past(!rst_i, 2)) |-> (sync_o == $past(async_i, 2)));

endmodule

// File: rtl/dodge_timer.sv
module dodge_timer #(
    parameter int DUR_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             done_o
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] dur_q;
    logic [DUR_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + (DUR_W+1)'(1);
    assign done_o  = run_i && tick_i && (cnt_inc >= {1'b0, dur_q});

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            dur_q <= ONE;
        end else if (load_i) begin
            cnt_q <= '0;
            dur_q <= (dur_i == '0) ? ONE : dur_i;
        end else if (run_i && tick_i && !done_o) begin
            cnt_q <= cnt_inc[DUR_W-1:0];
        end
    end

    // Counter restarts from zero on entry to a window (R5)
    p_clear_on_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cnt_q == '0));
    // Cycles without a tick leave the count untouched (R5)
    p_hold_no_tick_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !tick_i && !load_i) |=> $stable(cnt_q));
    // Count never reaches the captured length while running (R5)
    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |-> (cnt_q < dur_q));
    // Captured length is never zero (R8)
    p_dur_nonzero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        dur_q != '0);
    // Captured length frozen during a window (R9)
    p_dur_frozen_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !load_i) |=> $stable(dur_q));

endmodule

// File: rtl/dodge_fsm.sv
module dodge_fsm
    import dodge_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         btn_s_i,
    input  logic         done_i,
    output logic         load_o,
    output logic         run_o,
    output dodge_state_e state_o
);
    dodge_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY:   if (btn_s_i) st_d = ST_ACTIVE;
            ST_ACTIVE:  if (done_i)  st_d = ST_RELEASE;
            ST_RELEASE: if (!btn_s_i) st_d = ST_READY;
            default:    st_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_READY;
        else       st_q <= st_d;
    end

    assign load_o  = (st_q == ST_READY) && btn_s_i;
    assign run_o   = is_dodging(st_q);
    assign state_o = st_q;

    // Reset lands in ready (R2)
    p_reset_ready_r2: assert property (@(posedge clk_i)
        rst_i |=> (st_q == ST_READY));
    // Only the three legal codes (R1)
    p_legal_code_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q != dodge_state_e'(2'd3));
    // Ready holds without a press (R3)
    p_ready_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_READY && !btn_s_i) |=> (st_q == ST_READY));
    // Press in ready opens a window (R4)
    p_press_enters_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_READY && btn_s_i) |=> (st_q == ST_ACTIVE));
    // A window never drops straight back to ready (R6)
    p_active_exit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_ACTIVE) |=> (st_q != ST_READY));
    // Held button keeps release-wait (R6)
    p_no_rearm_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_RELEASE && btn_s_i) |=> (st_q == ST_RELEASE));
    // Letting go returns to ready (R7)
    p_release_exit_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_RELEASE && !btn_s_i) |=> (st_q == ST_READY));

endmodule

// File: rtl/dodge_ctrl.sv
module dodge_ctrl
    import dodge_pkg::*;
#(
    parameter int DUR_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             btn_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             dodge_o,
    output logic [1:0]       state_o
);
    logic         btn_s;
    logic         load;
    logic         run;
    logic         done;
    dodge_state_e st;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (btn_i),
        .sync_o  (btn_s)
    );

    dodge_timer #(.DUR_W(DUR_W)) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .run_i  (run),
        .tick_i (tick_i),
        .dur_i  (dur_i),
        .done_o (done)
    );

    dodge_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .btn_s_i (btn_s),
        .done_i  (done),
        .load_o  (load),
        .run_o   (run),
        .state_o (st)
    );

    assign dodge_o = run;
    assign state_o = st;

    // Flag and phase code agree at the ports (R4)
    p_flag_matches_code_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        dodge_o |-> (state_o == 2'd1));

endmodule

// File: tb/test_dodge_ctrl.sv
module test_dodge_ctrl;
    localparam int DUR_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b1;
    logic             btn = 1'b0;
    logic [DUR_W-1:0] dur = '0;
    logic             dodge;
    logic [1:0]       state;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int dodge_seen = 0;
    string cur_req = "R2";
    bit done_flag = 0;

    // behavioural reference
    int m_st = 0;
    int m_cnt = 0;
    int m_dur = 1;
    bit m_hist[$];

    always #10 clk = ~clk;

    dodge_ctrl #(.DUR_W(DUR_W)) i_dodge_ctrl (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .btn_i(btn),
        .dur_i(dur), .dodge_o(dodge), .state_o(state)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // model update at each rising edge
    always @(posedge clk) begin
        bit synced;
        cycles++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_dur = 1;
            m_hist = '{1'b0, 1'b0};
        end else begin
            synced = m_hist[0];
            case (m_st)
                0: if (synced) begin
                       m_st = 1; m_cnt = 0;
                       m_dur = (dur == 0) ? 1 : int'(dur);
                   end
                1: if (tick) begin
                       if (m_cnt + 1 >= m_dur) m_st = 2;
                       else m_cnt++;
                   end
                default: if (!synced) m_st = 0;
            endcase
            void'(m_hist.pop_front());
            m_hist.push_back(btn);
        end
    end

    // compare every cycle away from the edge
    always @(negedge clk) begin
        if (!done_flag && cycles > 0) begin
            check(cur_req, int'(state), m_st);
            check(cur_req, int'(dodge), (m_st == 1) ? 1 : 0);
            if (dodge) dodge_seen++;
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done_flag) begin
            done_flag = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // press, hold for hold_cyc, release, settle; returns dodge cycles seen
    task automatic press(input int d, input int hold_cyc, output int seen);
        dur = DUR_W'(d);
        dodge_seen = 0;
        btn = 1'b1;
        step(hold_cyc);
        btn = 1'b0;
        step(6);
        seen = dodge_seen;
    endtask

    initial begin
        int seen;
        step(3);
        cur_req = "R2";
        check("R2", int'(state), 0);
        check("R2", int'(dodge), 0);
        rst = 1'b0;

        cur_req = "R3";
        step(10);
        check("R3", int'(state), 0);

        // R4: press latency of three edges
        cur_req = "R4";
        dur = 4'd3;
        btn = 1'b1;
        step(2);
        check("R4", int'(state), 0);
        step(1);
        check("R4", int'(state), 1);
        check("R4", int'(dodge), 1);
        // R6: held long after the window
        cur_req = "R6";
        step(20);
        check("R6", int'(state), 2);
        check("R6", int'(dodge), 0);
        // R7: release returns on third edge
        cur_req = "R7";
        btn = 1'b0;
        step(2);
        check("R7", int'(state), 2);
        step(1);
        check("R7", int'(state), 0);
        step(3);

        // R5: window length with ticks every cycle
        cur_req = "R5";
        press(5, 12, seen);
        check("R5", seen, 5);

        // R8: zero duration behaves as one
        cur_req = "R8";
        press(0, 8, seen);
        check("R8", seen, 1);

        // R9: duration changed mid-window
        cur_req = "R9";
        dur = 4'd6;
        dodge_seen = 0;
        btn = 1'b1;
        step(4);
        dur = 4'd1;
        step(10);
        btn = 1'b0;
        step(6);
        check("R9", dodge_seen, 6);

        // R5: sparse ticks, model comparison; no ticks stretches window
        cur_req = "R5";
        dur = 4'd3;
        btn = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick = (i % 3 == 0);
            step(1);
        end
        tick = 1'b0;
        btn = 1'b0;
        step(6);
        btn = 1'b1;
        step(12);
        check("R5", int'(state), 1);
        tick = 1'b1;
        step(5);
        btn = 1'b0;
        step(6);

        // R6: brief release glitch then re-press
        cur_req = "R6";
        press(2, 10, seen);
        btn = 1'b1;
        step(1);
        btn = 1'b0;
        step(1);
        btn = 1'b1;
        step(10);
        btn = 1'b0;
        step(6);

        // R2: reset mid-window
        cur_req = "R2";
        dur = 4'd9;
        btn = 1'b1;
        step(5);
        rst = 1'b1;
        step(1);
        check("R2", int'(state), 0);
        check("R2", int'(dodge), 0);
        btn = 1'b0;
        rst = 1'b0;
        step(4);

        // R1: only legal codes seen
        cur_req = "R1";
        check("R1", (state == 2'd3) ? 1 : 0, 0);

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule